// File: doc/BRIEF.md
# Poll and Status Readback Unit

This block sits beside the request, in-service and mask registers of a priority interrupt controller and owns the third operation command word, the one that steers host reads. A host write to the even address whose bit 4 is 0 and bit 3 is 1 carries three independent fields: a poll request, a status-register select, and a special-mask-mode update. The unit keeps the resulting state and forms the byte a host read returns.

When poll is armed, the next chip-selected read turns into a software acknowledge. The read returns a pending flag and the binary level reported by the priority resolver, and a one-hot strobe tells the in-service register to set that level's bit. A freeze output holds request capture steady from the cycle after the arming write through the poll read. Without poll, reads at the odd address return the mask register. Reads at the even address return whichever of the request or in-service registers was last selected, for as many reads as the host makes.

All strobes are single-cycle, active-high, and sampled on the rising clock edge. The read data is combinational and is valid during the read cycle.

Top module: `poll_status_unit`

## Requirements
- R1: After synchronous reset, special mask mode is off, freeze is low, poll is disarmed and the request register is the selected status register.
- R2: A write counts as the command only when cs_i and wr_i are high, a0_i is 0, wdata_i bit 4 is 0 and bit 3 is 1. Any other write leaves selection, special mask mode and poll state unchanged.
- R3: A command with bit 2 set arms poll. freeze_o is high from the next cycle until the end of the poll read cycle.
- R4: While poll is armed, the next cycle with cs_i and rd_i high, at either a0_i value, returns the poll byte. Bit 7 equals hi_valid_i, bits 2:0 equal hi_level_i when bit 7 is 1, and every other bit is 0. With nothing pending the byte is 0x00.
- R5: On that poll read, if hi_valid_i is 1, isr_set_o is one-hot at hi_level_i for that cycle. It is zero on every other cycle.
- R6: A command with bit 1 (register read) set selects the in-service register when bit 0 is 1 and the request register when bit 0 is 0. A command with bit 1 clear leaves the selection unchanged.
- R7: A read at a0_i = 0 with poll disarmed returns the selected register, and the selection holds over any number of reads.
- R8: A read at a0_i = 1 with poll disarmed returns the mask register.
- R9: A poll read disarms poll, and the next plain read returns the register selected before it.
- R10: A command with bit 6 set loads special mask mode from bit 5. A command with bit 6 clear leaves it unchanged.
- R11: rd_data_o is 0x00 on any cycle without cs_i and rd_i both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| a0_i | input | 1 | Address bit 0 |
| wdata_i | input | 8 | Write data |
| irr_i | input | NUM_LEVELS | Current request vector |
| isr_i | input | NUM_LEVELS | Current in-service vector |
| imr_i | input | NUM_LEVELS | Current mask vector |
| hi_valid_i | input | 1 | Priority resolver has a pending unmasked level |
| hi_level_i | input | LVL_W | Highest pending unmasked level |
| rd_data_o | output | 8 | Read data |
| isr_set_o | output | NUM_LEVELS | One-hot in-service set strobe for a poll |
| freeze_o | output | 1 | Hold request capture |
| smm_o | output | 1 | Special mask mode flag |

## Verification
The bench uses the default of eight levels, so the level code spans all three low bits of the poll byte. Levels 0, 5 and 7 exercise the lowest and highest strobe positions and a mixed code pattern. With eight levels the vectors fill the byte, so a mask, request or in-service value placed in the wrong bits shows up on every read. A long run of random reads and writes with random register contents follows the directed cases, and a behavioural model checks every cycle.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int BYTE_W = 8;

    // Command field positions (software visible, so fixed)
    localparam int F_ESMM  = 6;
    localparam int F_SMM   = 5;
    localparam int F_TAG_H = 4;
    localparam int F_TAG_L = 3;
    localparam int F_POLL  = 2;
    localparam int F_RR    = 1;
    localparam int F_RIS   = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        SEL_REQ = 1'b0,
        SEL_SVC = 1'b1
    } stat_sel_e;

    typedef struct packed {
        logic      hit;
        logic      poll;
        logic      sel_upd;
        stat_sel_e sel;
        logic      smm_upd;
        logic      smm_val;
    } op3_cmd_t;

    function automatic op3_cmd_t decode_op3(input logic wr_hit, input logic a0,
                                            input byte_t d);
        op3_cmd_t c;
        c.hit     = wr_hit && !a0 && !d[F_TAG_H] && d[F_TAG_L];
        c.poll    = d[F_POLL];
        c.sel_upd = d[F_RR];
        c.sel     = stat_sel_e'(d[F_RIS]);
        c.smm_upd = d[F_ESMM];
        c.smm_val = d[F_SMM];
        return c;
    endfunction

endpackage

// File: rtl/op3_decoder.sv
module op3_decoder
    import poll_pkg::*;
(
    input  logic     wr_hit_i,
    input  logic     a0_i,
    input  byte_t    wdata_i,
    output op3_cmd_t cmd_o
);
    // Bit 7 carries nothing for this command
    logic unused_msb;
    assign unused_msb = wdata_i[BYTE_W-1];

    always_comb cmd_o = decode_op3(wr_hit_i, a0_i, wdata_i);
endmodule

// File: rtl/op3_mode_regs.sv
module op3_mode_regs
    import poll_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  op3_cmd_t  cmd_i,
    input  logic      rd_hit_i,
    output stat_sel_e sel_o,
    output logic      smm_o,
    output logic      poll_armed_o
);
    stat_sel_e sel_q;
    logic      smm_q;
    logic      poll_q;
    logic      poll_rd;

    assign poll_rd = rd_hit_i && poll_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= SEL_REQ;
            smm_q  <= 1'b0;
            poll_q <= 1'b0;
        end else begin
            if (cmd_i.hit && cmd_i.sel_upd) sel_q <= cmd_i.sel;
            if (cmd_i.hit && cmd_i.smm_upd) smm_q <= cmd_i.smm_val;
            if (cmd_i.hit && cmd_i.poll)    poll_q <= 1'b1;
            else if (poll_rd)               poll_q <= 1'b0;
        end
    end

    assign sel_o        = sel_q;
    assign smm_o        = smm_q;
    assign poll_armed_o = poll_q;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!poll_q && !smm_q && sel_q == SEL_REQ));

    a_r3_poll_arms: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.hit && cmd_i.poll) |=> poll_q);

    a_r9_poll_disarms: assert property (@(posedge clk) disable iff (rst)
        (poll_rd && !(cmd_i.hit && cmd_i.poll)) |=> !poll_q);

    a_r6_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i.hit && cmd_i.sel_upd) |=> $stable(sel_q));

    a_r10_smm_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i.hit && cmd_i.smm_upd) |=> $stable(smm_q));
endmodule

// File: rtl/op3_readback.sv
module op3_readback
    import poll_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_hit_i,
    input  logic                  a0_i,
    input  logic                  poll_armed_i,
    input  stat_sel_e             sel_i,
    input  logic [NUM_LEVELS-1:0] irr_i,
    input  logic [NUM_LEVELS-1:0] isr_i,
    input  logic [NUM_LEVELS-1:0] imr_i,
    input  logic                  hi_valid_i,
    input  logic [LVL_W-1:0]      hi_level_i,
    output byte_t                 rd_data_o,
    output logic [NUM_LEVELS-1:0] isr_set_o
);
    localparam int PAD_W = BYTE_W - 1 - LVL_W;

    logic  poll_rd;
    byte_t poll_byte;
    byte_t stat_byte;

    assign poll_rd   = rd_hit_i && poll_armed_i;
    assign poll_byte = hi_valid_i ? {1'b1, {PAD_W{1'b0}}, hi_level_i} : '0;
    assign stat_byte = (sel_i == SEL_SVC) ? BYTE_W'(isr_i) : BYTE_W'(irr_i);

    always_comb begin
        if (!rd_hit_i)    rd_data_o = '0;
        else if (poll_rd) rd_data_o = poll_byte;
        else if (a0_i)    rd_data_o = BYTE_W'(imr_i);
        else              rd_data_o = stat_byte;
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_set
        assign isr_set_o[g] = poll_rd && hi_valid_i && (hi_level_i == LVL_W'(g));
    end

    a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_set_o));

    a_r5_strobe_only_on_poll: assert property (@(posedge clk) disable iff (rst)
        (|isr_set_o) |-> (rd_hit_i && poll_armed_i));

    a_r4_poll_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_hit_i && poll_armed_i) |-> (rd_data_o[BYTE_W-2:LVL_W] == '0));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_hit_i |-> (rd_data_o == '0));
endmodule

// File: rtl/poll_status_unit.sv
module poll_status_unit
    import poll_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_i,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic                  a0_i,
    input  logic [7:0]            wdata_i,
    input  logic [NUM_LEVELS-1:0] irr_i,
    input  logic [NUM_LEVELS-1:0] isr_i,
    input  logic [NUM_LEVELS-1:0] imr_i,
    input  logic                  hi_valid_i,
    input  logic [LVL_W-1:0]      hi_level_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_LEVELS-1:0] isr_set_o,
    output logic                  freeze_o,
    output logic                  smm_o
);
    logic      wr_hit;
    logic      rd_hit;
    op3_cmd_t  cmd;
    stat_sel_e sel;
    logic      poll_armed;

    assign wr_hit = cs_i && wr_i;
    assign rd_hit = cs_i && rd_i;

    op3_decoder u_dec (
        .wr_hit_i (wr_hit),
        .a0_i     (a0_i),
        .wdata_i  (wdata_i),
        .cmd_o    (cmd)
    );

    op3_mode_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .rd_hit_i     (rd_hit),
        .sel_o        (sel),
        .smm_o        (smm_o),
        .poll_armed_o (poll_armed)
    );

    op3_readback #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W)
    ) u_rb (
        .clk          (clk),
        .rst          (rst),
        .rd_hit_i     (rd_hit),
        .a0_i         (a0_i),
        .poll_armed_i (poll_armed),
        .sel_i        (sel),
        .irr_i        (irr_i),
        .isr_i        (isr_i),
        .imr_i        (imr_i),
        .hi_valid_i   (hi_valid_i),
        .hi_level_i   (hi_level_i),
        .rd_data_o    (rd_data_o),
        .isr_set_o    (isr_set_o)
    );

    assign freeze_o = poll_armed;

    a_r3_freeze_until_read: assert property (@(posedge clk) disable iff (rst)
        (freeze_o && !rd_hit && !wr_hit) |=> freeze_o);
endmodule

// File: tb/poll_status_unit_tb_top.sv
module poll_status_unit_tb_top;
    localparam int NL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cs = 0, rd = 0, wr = 0, a0 = 0;
    logic [7:0]    wd = '0;
    logic [NL-1:0] irr = '0, isr = '0, imr = '0;
    logic          hv = 0;
    logic [2:0]    hl = '0;
    logic [7:0]    rdat;
    logic [NL-1:0] setv;
    logic          frz, smm;

    poll_status_unit #(.NUM_LEVELS(NL)) dut_i (
        .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .a0_i(a0),
        .wdata_i(wd), .irr_i(irr), .isr_i(isr), .imr_i(imr),
        .hi_valid_i(hv), .hi_level_i(hl), .rd_data_o(rdat),
        .isr_set_o(setv), .freeze_o(frz), .smm_o(smm)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model state
    bit m_svc  = 0;
    bit m_smm  = 0;
    bit m_poll = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: drive after falling edge, compare before rising edge
    task automatic step(input logic c, input logic r, input logic w,
                        input logic a, input logic [7:0] d, input string tag);
        logic [7:0]    e_rd;
        logic [NL-1:0] e_set;
        bit            rdh, wrh, prd;
        @(negedge clk);
        cs = c; rd = r; wr = w; a0 = a; wd = d;
        irr = NL'($urandom); isr = NL'($urandom); imr = NL'($urandom);
        #2;
        rdh = c && r;
        wrh = c && w;
        prd = rdh && m_poll;
        e_set = '0;
        if (!rdh)       e_rd = 8'h00;
        else if (prd)   e_rd = hv ? (8'h80 | {5'b0, hl}) : 8'h00;
        else if (a)     e_rd = imr;
        else            e_rd = m_svc ? isr : irr;
        if (prd && hv)  e_set = NL'(1) << hl;
        chk(!rdh ? "R11" : prd ? "R4" : a ? "R8" : "R7", {tag, " read data"}, rdat, e_rd);
        chk("R5", {tag, " set strobe"}, setv, e_set);
        chk("R3", {tag, " freeze"}, frz, m_poll);
        chk("R10", {tag, " smm"}, smm, m_smm);
        // next state
        if (wrh && !a && !d[4] && d[3]) begin
            if (d[6]) m_smm = d[5];
            if (d[1]) m_svc = d[0];
            if (d[2]) m_poll = 1;
            else if (prd) m_poll = 0;
        end else if (prd) begin
            m_poll = 0;
        end
    endtask

    task automatic wr_op(input logic a, input logic [7:0] d, input string tag);
        step(1, 0, 1, a, d, tag);
    endtask

    task automatic rd_op(input logic a, input string tag);
        step(1, 1, 0, a, 8'h00, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state, request register selected
        step(0, 0, 0, 0, 8'h00, "R1");
        rd_op(0, "R1");
        // R7: selection persists
        rd_op(0, "R7"); rd_op(0, "R7");
        // R6: select in-service, hold with RR=0, back to request
        wr_op(0, 8'h0B, "R6");
        rd_op(0, "R6"); rd_op(0, "R7"); rd_op(0, "R7");
        wr_op(0, 8'h09, "R6");
        rd_op(0, "R6");
        wr_op(0, 8'h0A, "R6");
        rd_op(0, "R6");
        // R8: mask read
        rd_op(1, "R8"); rd_op(1, "R8");
        // R2: writes that are not the command
        wr_op(1, 8'h0B, "R2"); rd_op(0, "R2");
        wr_op(0, 8'h1B, "R2"); rd_op(0, "R2");
        wr_op(0, 8'h03, "R2"); rd_op(0, "R2");
        step(0, 0, 1, 0, 8'h0B, "R2"); rd_op(0, "R2");
        wr_op(1, 8'h6C, "R2"); step(0, 0, 0, 0, 8'h00, "R2");
        // R10: special mask mode
        wr_op(0, 8'h28, "R10");
        wr_op(0, 8'h68, "R10"); step(0, 0, 0, 0, 8'h00, "R10");
        wr_op(0, 8'h28, "R10"); wr_op(0, 8'h08, "R10");
        wr_op(0, 8'h48, "R10"); step(0, 0, 0, 0, 8'h00, "R10");
        // R3/R4/R5/R9: poll with in-service selected
        wr_op(0, 8'h0B, "R6");
        wr_op(0, 8'h0C, "R3");
        step(0, 0, 0, 0, 8'h00, "R3"); step(0, 0, 0, 0, 8'h00, "R3");
        hv = 1; hl = 3'd5;
        rd_op(0, "R4");
        rd_op(0, "R9"); rd_op(0, "R9");
        wr_op(0, 8'h0C, "R3");
        hv = 0; hl = 3'd6;
        rd_op(0, "R4");
        rd_op(0, "R9");
        wr_op(0, 8'h0C, "R3");
        hv = 1; hl = 3'd7;
        rd_op(1, "R4");
        rd_op(1, "R9");
        wr_op(0, 8'h0C, "R3");
        hv = 1; hl = 3'd0;
        rd_op(0, "R5");
        // poll combined with a new selection
        wr_op(0, 8'h0E, "R6");
        hv = 1; hl = 3'd2;
        rd_op(0, "R4");
        rd_op(0, "R9");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            hv = 1'($urandom); hl = 3'($urandom);
            d = 8'($urandom);
            if ($urandom_range(0, 3) != 0) begin d[4] = 0; d[3] = 1; end
            case (op)
                0:       step(0, 0, 0, 1'($urandom), d, "R11");
                1, 2:    rd_op(1'($urandom), "R7");
                3, 4:    wr_op(($urandom_range(0, 4) == 0), d, "R2");
                default: step(0, 1'($urandom), 1'($urandom), 1'($urandom), d, "R11");
            endcase
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule